// File: doc/BRIEF.md
# Debug Register Access Controller

This block holds the eight-entry debug register file of a processor core: four breakpoint address registers, a status register and a control register. The core performs reads and writes through a single strobe-based port carrying an index from 0 to 7. Read data comes back in the same cycle as the strobe. Writes take effect at the next rising clock edge.

A debug-extensions mode input changes how indices 4 and 5 behave. With the mode clear, they are aliases of the status and control registers. With the mode set, an access to either index raises an illegal-operation fault. Such an access changes nothing and returns zero.

Every control write forces a fixed set of always-one bits. The block then works out which of the four breakpoint slots must be re-armed by the matching logic downstream. It reports those slots as a one-cycle pulse per slot. A level output tells the port-I/O checker that at least one enabled slot watches I/O.

Top module: `dbg_reg_access`

## Requirements
- R1: A write to index 0, 1, 2 or 3 stores the data in the address register of slot 0, 1, 2 or 3 respectively. A read of that index returns the stored value in the same cycle as the strobe.
- R2: Index 6 reads and writes the status register. Index 7 reads and writes the control register.
- R3: While `ext_mode` is 0, index 4 reads and writes the status register and index 5 reads and writes the control register.
- R4: While `ext_mode` is 1, an access to index 4 or 5 raises `fault` in the strobe cycle only. It leaves all registers unchanged, returns zero on `rd_data` and produces no `reconf` pulse.
- R5: Every control write stores the written data ORed with the fixed-ones mask (default 32'h0000_0400), so the mask bits always read as 1.
- R6: The control register uses these fields for slot i. Bit 2i is the local enable and bit 2i+1 is the global enable; the slot's collective enable is the OR of the two. A control write that changes no bit above bit 7 pulses `reconf[i]` exactly for the slots whose collective enable changed.
- R7: A control write that changes any bit above bit 7 (after the forced ones are applied) pulses all four `reconf` bits.
- R8: Bits 16+4i and 17+4i of the control register hold the type of slot i; the code 2'b10 means I/O. Writing the address register of slot i pulses `reconf[i]` when slot i is enabled and its type is not I/O. Otherwise the write produces no pulse.
- R9: `io_watch_active` is 1 exactly while at least one slot is enabled with type 2'b10.
- R10: After reset, the address and status registers read 0, the control register reads the fixed-ones mask, and `fault`, `reconf` and `io_watch_active` are 0.
- R11: `reconf` is high only during the single cycle after the clock edge that completes the causing write. An access to index 0–3, 6 or 7 never faults, and neither does any access while `ext_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Register index 0–7 |
| acc_wdata | input | XLEN | Write data |
| ext_mode | input | 1 | Debug-extensions mode; disables aliases 4 and 5 |
| rd_data | output | XLEN | Read data; zero unless a permitted read is strobed |
| fault | output | 1 | Illegal-operation fault, with the strobe |
| reconf | output | NUM_SLOTS | One-cycle per-slot re-arm pulse |
| io_watch_active | output | 1 | An enabled slot is of I/O type |

## Verification
A wrong stored register value appears at `rd_data` on the next read of any index that maps to it, including the aliases. A corrupted control register also shows at once on `io_watch_active` and in the `reconf` pattern of the following write. The bench walks every index under both mode settings and reads all eight indices back after each write. It also sweeps all 256 enable-byte values under two slot-type layouts, so a wrong fold or type decode shows on the cycle after the causing write.

// File: rtl/dbg_reg_pkg.sv
package dbg_reg_pkg;
  typedef enum logic [1:0] {
    TGT_ADDR = 2'd0,
    TGT_STAT = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_NONE = 2'd3
  } dbg_tgt_e;

  localparam logic [1:0] SLOT_TYPE_IO = 2'b10;
endpackage

// File: rtl/dbg_idx_decode.sv
module dbg_idx_decode
  import dbg_reg_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] idx,
  input  logic       ext_mode,
  output dbg_tgt_e   tgt,
  output logic       fault
);
  always_comb begin
    tgt   = TGT_NONE;
    fault = 1'b0;
    unique case (idx)
      3'd0, 3'd1, 3'd2, 3'd3: tgt = TGT_ADDR;
      3'd6:                   tgt = TGT_STAT;
      3'd7:                   tgt = TGT_CTRL;
      3'd4: begin
        if (ext_mode) fault = valid;
        else          tgt   = TGT_STAT;
      end
      default: begin
        if (ext_mode) fault = valid;
        else          tgt   = TGT_CTRL;
      end
    endcase
  end
endmodule

// File: rtl/dbg_ctrl_change.sv
module dbg_ctrl_change #(
  parameter int XLEN      = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic [XLEN-1:0]      old_ctrl,
  input  logic [XLEN-1:0]      new_ctrl,
  output logic [NUM_SLOTS-1:0] mask
);
  localparam int EN_BITS = 2 * NUM_SLOTS;
  localparam logic [XLEN-1:0] EN_MASK = {{(XLEN-EN_BITS){1'b0}}, {EN_BITS{1'b1}}};

  logic [XLEN-1:0] diff;
  logic            upper_changed;

  assign diff          = old_ctrl ^ new_ctrl;
  assign upper_changed = |(diff & ~EN_MASK);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic old_en, new_en;
    assign old_en  = |old_ctrl[2*i +: 2];
    assign new_en  = |new_ctrl[2*i +: 2];
    assign mask[i] = upper_changed | (old_en ^ new_en);
  end
endmodule

// File: rtl/dbg_slot_status.sv
module dbg_slot_status
  import dbg_reg_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [2*NUM_SLOTS-1:0]      en_bits,
  input  logic [NUM_SLOTS-1:0][1:0]   slot_type,
  output logic [NUM_SLOTS-1:0]        slot_en,
  output logic [NUM_SLOTS-1:0]        slot_io,
  output logic                        io_any
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_en[i] = |en_bits[2*i +: 2];
    assign slot_io[i] = slot_en[i] && (slot_type[i] == SLOT_TYPE_IO);
  end
  assign io_any = |slot_io;
endmodule

// File: rtl/dbg_reg_access.sv
module dbg_reg_access
  import dbg_reg_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NUM_SLOTS  = 4,
  parameter int              TYPE_LSB   = 16,
  parameter logic [XLEN-1:0] FIXED_ONES = 32'h0000_0400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [2:0]           acc_idx,
  input  logic [XLEN-1:0]      acc_wdata,
  input  logic                 ext_mode,
  output logic [XLEN-1:0]      rd_data,
  output logic                 fault,
  output logic [NUM_SLOTS-1:0] reconf,
  output logic                 io_watch_active
);
  localparam int SLOT_W  = $clog2(NUM_SLOTS);
  localparam int EN_BITS = 2 * NUM_SLOTS;

  logic [NUM_SLOTS-1:0][XLEN-1:0] addr_q, addr_d;
  logic [XLEN-1:0]                stat_q, stat_d;
  logic [XLEN-1:0]                ctrl_q, ctrl_d, ctrl_wr;
  logic [NUM_SLOTS-1:0]           reconf_q, reconf_d;

  dbg_tgt_e                     tgt;
  logic                         wr_ok, rd_ok;
  logic [SLOT_W-1:0]            slot;
  logic [NUM_SLOTS-1:0]         ctrl_mask, slot_en, slot_io;
  logic [NUM_SLOTS-1:0][1:0]    slot_type;

  dbg_idx_decode u_dec (
    .valid    (acc_valid),
    .idx      (acc_idx),
    .ext_mode (ext_mode),
    .tgt      (tgt),
    .fault    (fault)
  );

  assign ctrl_wr = acc_wdata | FIXED_ONES;

  dbg_ctrl_change #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS)) u_chg (
    .old_ctrl (ctrl_q),
    .new_ctrl (ctrl_wr),
    .mask     (ctrl_mask)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_type
    assign slot_type[i] = ctrl_q[TYPE_LSB + 4*i +: 2];
  end

  dbg_slot_status #(.NUM_SLOTS(NUM_SLOTS)) u_stat (
    .en_bits   (ctrl_q[EN_BITS-1:0]),
    .slot_type (slot_type),
    .slot_en   (slot_en),
    .slot_io   (slot_io),
    .io_any    (io_watch_active)
  );

  assign slot  = acc_idx[SLOT_W-1:0];
  assign wr_ok = acc_valid &&  acc_write && !fault;
  assign rd_ok = acc_valid && !acc_write && !fault;

  // next state
  always_comb begin
    addr_d   = addr_q;
    stat_d   = stat_q;
    ctrl_d   = ctrl_q;
    reconf_d = '0;
    if (wr_ok) begin
      unique case (tgt)
        TGT_ADDR: begin
          addr_d[slot] = acc_wdata;
          if (slot_en[slot] && !slot_io[slot]) reconf_d[slot] = 1'b1;
        end
        TGT_STAT: stat_d = acc_wdata;
        TGT_CTRL: begin
          ctrl_d   = ctrl_wr;
          reconf_d = ctrl_mask;
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stat_q   <= '0;
      ctrl_q   <= FIXED_ONES;
      reconf_q <= '0;
    end else begin
      if (wr_ok) begin
        addr_q <= addr_d;
        stat_q <= stat_d;
        ctrl_q <= ctrl_d;
      end
      reconf_q <= reconf_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      unique case (tgt)
        TGT_ADDR: rd_data = addr_q[slot];
        TGT_STAT: rd_data = stat_q;
        TGT_CTRL: rd_data = ctrl_q;
        default:  rd_data = '0;
      endcase
    end
  end

  assign reconf = reconf_q;

  // R4
  fault_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (acc_valid && ext_mode));
  // R4
  fault_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(stat_q) && $stable(ctrl_q) && $stable(addr_q) && reconf == '0));
  // R4
  rd_zero_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rd_data == '0));
  // R5
  fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & FIXED_ONES) == FIXED_ONES));
  // R11
  reconf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reconf != '0) |-> $past(acc_valid && acc_write && !fault));
  // R9
  io_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_watch_active |-> (ctrl_q[EN_BITS-1:0] != '0));
endmodule

// File: tb/dbg_reg_access_tb.sv
`timescale 1ns/1ps
module dbg_reg_access_tb_top;
  localparam logic [31:0] FIXED = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, ext_mode;
  logic [2:0]  acc_idx;
  logic [31:0] acc_wdata, rd_data;
  logic        fault, io_watch_active;
  logic [3:0]  reconf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m_addr [4];
  logic [31:0] m_stat, m_ctrl;

  always #2 clk = ~clk;

  dbg_reg_access dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .ext_mode(ext_mode),
    .rd_data(rd_data), .fault(fault), .reconf(reconf),
    .io_watch_active(io_watch_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic en_of(input logic [31:0] c, input int i);
    return c[2*i] | c[2*i+1];
  endfunction

  function automatic logic [1:0] type_of(input logic [31:0] c, input int i);
    return c[16+4*i +: 2];
  endfunction

  function automatic logic exp_io(input logic [31:0] c);
    logic r = 0;
    for (int i = 0; i < 4; i++) if (en_of(c, i) && type_of(c, i) == 2'b10) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input int idx, input logic ext);
    case (idx)
      0, 1, 2, 3: return m_addr[idx];
      6: return m_stat;
      7: return m_ctrl;
      4: return ext ? 32'h0 : m_stat;
      default: return ext ? 32'h0 : m_ctrl;
    endcase
  endfunction

  task automatic wr(input int idx, input logic ext, input logic [31:0] d);
    logic flt;
    logic [3:0] er;
    logic [31:0] nc;
    string tag;
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_idx = idx[2:0]; acc_wdata = d; ext_mode = ext;
    #1;
    flt = ext && (idx == 4 || idx == 5);
    chk(flt ? "R4 fault on write" : "R11 no fault on write", {31'b0, fault}, {31'b0, flt});
    er = 0; tag = "R11 no reconf";
    if (flt) tag = "R4 no reconf";
    else if (idx < 4) begin
      m_addr[idx] = d;
      if (en_of(m_ctrl, idx) && type_of(m_ctrl, idx) != 2'b10) er[idx] = 1;
      tag = "R8 addr reconf";
    end else if (idx == 6 || idx == 4) m_stat = d;
    else begin
      nc = d | FIXED;
      if (((m_ctrl ^ nc) & ~32'hFF) != 0) begin er = 4'hF; tag = "R7 reconf all"; end
      else begin
        for (int i = 0; i < 4; i++) er[i] = en_of(m_ctrl, i) ^ en_of(nc, i);
        tag = "R6 enable fold";
      end
      m_ctrl = nc;
    end
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    chk(tag, {28'b0, reconf}, {28'b0, er});
    chk("R9 io level", {31'b0, io_watch_active}, {31'b0, exp_io(m_ctrl)});
  endtask

  task automatic rd(input int idx, input logic ext);
    logic flt;
    string tag;
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_idx = idx[2:0]; ext_mode = ext;
    #1;
    flt = ext && (idx == 4 || idx == 5);
    if (idx < 4) tag = "R1 addr read";
    else if (idx >= 6) tag = "R2 stat/ctrl read";
    else if (!ext) tag = "R3 alias read";
    else tag = "R4 fault read";
    chk(tag, rd_data, model_rd(idx, ext));
    chk(flt ? "R4 fault pulse" : "R11 no fault", {31'b0, fault}, {31'b0, flt});
    if (!flt && (idx == 7 || idx == 5))
      chk("R5 fixed ones", rd_data & FIXED, FIXED);
  endtask

  task automatic rd_all();
    for (int e = 0; e < 2; e++)
      for (int k = 0; k < 8; k++) rd(k, e[0]);
    @(negedge clk);
    acc_valid = 0;
    #1;
    chk("R4 fault only with strobe", {31'b0, fault}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_idx = 0; acc_wdata = 0; ext_mode = 0;
    for (int i = 0; i < 4; i++) m_addr[i] = 0;
    m_stat = 0; m_ctrl = FIXED;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset fault", {31'b0, fault}, 32'h0);
    chk("R10 reset reconf", {28'b0, reconf}, 32'h0);
    chk("R10 reset io", {31'b0, io_watch_active}, 32'h0);
    rd(7, 0); rd(6, 0); rd(0, 0); rd(3, 0);

    // every index under both modes, full readback after each
    for (int e = 0; e < 2; e++)
      for (int k = 0; k < 8; k++) begin
        wr(k, e[0], 32'hA500_0000 ^ (k << 12) ^ (e << 20) ^ (k * 32'h0001_0101));
        rd_all();
      end

    // enable-byte sweep under two type layouts, with address writes
    for (int h = 0; h < 2; h++) begin
      wr(7, 0, (h == 0) ? 32'h3220_0000 : 32'h2222_0000);
      for (int v = 0; v < 256; v++) begin
        wr((v % 3 == 0) ? 5 : 7, 0, ((h == 0) ? 32'h3220_0000 : 32'h2222_0000) | v);
        wr(v % 4, 0, 32'h1000_0000 + v);
      end
      rd_all();
    end

    // enable-only write that leaves collective enables unchanged
    wr(7, 0, 32'h0000_0001);
    wr(7, 0, 32'h0000_0002);
    wr(7, 0, 32'h0000_0003);
    rd_all();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule